// File: doc/BRIEF.md
# Hub Reset Strap Capture Controller

This block turns a handful of board strap pins into the power-on configuration of a three-port hub. While the active-low hardware reset is held, the strap pins are only watched. The one exception is the power-polarity strap, which steers the port power-enable pins at once so that no port is switched on during reset. When reset is released, the straps pass through a two-flop synchronizer and are captured a single time. After that they are ignored until the next reset.

From the captured values the block decodes several settings: the configuration source, the disabled port, the non-removable ports and the ganged or individual power mode. It also drives the three port power-enable pins and the three LED pins. Each of these is corrected to the active level set by its strap. The surrounding hub logic supplies the power and LED requests as active-high signals and reads the decoded configuration.

Top module: `hub_strap_latch`

## Requirements
- R1: While `rst_n` is low, every bit of `pwr_en` equals the inverse of `strap_pol` and follows it combinationally. `led_out` reads 000, `cfg_mode` reads 0 and `cfg_ready` reads 0.
- R2: The straps are captured on the third rising clock edge after `rst_n` rises, and `cfg_ready` goes to 1 on that edge. Strap changes after that edge do not change any output.
- R3: A captured polarity of 1 makes `pwr_en[i]` equal to the port's active-high power demand. A captured polarity of 0 makes `pwr_en[i]` its inverse.
- R4: The select straps decode as {`strap_sel[1]`,`strap_sel[0]`}. A value of 0x gives `cfg_mode`=1 (serial management slave at 7-bit address 0101101). A value of 10 gives `cfg_mode`=2 (internal defaults plus straps). A value of 11 gives `cfg_mode`=3 (serial EEPROM).
- R5: In `cfg_mode` 2, `strap_nonrem` sets `non_removable` (bit 0 = port 1) as follows: 00 gives 000, 01 gives 001, 10 gives 011 and 11 gives 111.
- R6: In `cfg_mode` 2, `strap_pdis`=1 sets `port_off`=100, and port 3 then stays unpowered whatever its request. `strap_pdis`=0 sets `port_off`=000.
- R7: In `cfg_mode` 2, `strap_gang`=1 sets `ganged`=1, and `pwr_req[0]` alone is then the demand of all three ports. With `strap_gang`=0, each port uses its own request bit.
- R8: In `cfg_mode` 2, each LED pin is active low if the strap it shares was captured as 1, and active high if it was captured as 0. LED 1 shares `strap_nonrem[0]`, LED 2 shares `strap_nonrem[1]` and LED 3 shares `strap_pdis`.
- R9: In `cfg_mode` 1 or 3, `port_off`, `non_removable` and `ganged` all read 0, and every LED pin is active low (`led_out` = ~`led_req`). This means that an EEPROM source that never answers leaves all fields at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_pol | input | 1 | Power-enable polarity strap |
| strap_sel | input | 2 | Configuration source select straps |
| strap_nonrem | input | 2 | Non-removable port count strap |
| strap_pdis | input | 1 | Port 3 disable strap |
| strap_gang | input | 1 | Ganged power and sensing strap |
| pwr_req | input | 3 | Active-high per-port power requests |
| led_req | input | 3 | Active-high per-port LED requests |
| cfg_ready | output | 1 | Straps have been captured |
| cfg_mode | output | 2 | 0 pending, 1 management slave, 2 straps, 3 EEPROM |
| port_off | output | 3 | Permanently disabled ports |
| non_removable | output | 3 | Ports with fixed devices |
| ganged | output | 1 | Ganged power switching and sensing |
| pwr_en | output | 3 | Polarity-corrected power-enable pins |
| led_out | output | 3 | Polarity-corrected LED pins |

## Verification
The reset-time power-enable value has no register on its path, so it is checked in the same cycle as a change on `strap_pol` while reset is held. The captured configuration appears on the third rising edge after reset is released. The bench samples it at the falling edge that follows that edge, and it also confirms that `cfg_ready` is still low one edge before. After capture, `pwr_en` and `led_out` are combinational in the requests, so they are sampled one time step after each request change. Strap changes made after capture are followed by a full-cycle wait before the outputs are compared with their earlier values.

// File: rtl/hub_strap_latch.sv
module hub_strap_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_pol,
  input  logic [1:0] strap_sel,
  input  logic [1:0] strap_nonrem,
  input  logic       strap_pdis,
  input  logic       strap_gang,
  input  logic [2:0] pwr_req,
  input  logic [2:0] led_req,
  output logic       cfg_ready,
  output logic [1:0] cfg_mode,
  output logic [2:0] port_off,
  output logic [2:0] non_removable,
  output logic       ganged,
  output logic [2:0] pwr_en,
  output logic [2:0] led_out
);

  logic [6:0] pins, sync1, sync2, held;
  logic [1:0] rst_sync;

  assign pins = {strap_pol, strap_sel, strap_nonrem, strap_pdis, strap_gang};

  always_ff @(posedge clk) begin
    sync1 <= pins;
    sync2 <= sync1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_ready <= 1'b0;
      held      <= '0;
    end else if (rst_sync[1] && !cfg_ready) begin
      cfg_ready <= 1'b1;
      held      <= sync2;
    end

  logic       pol_q, pdis_q, gang_q, use_straps;
  logic [1:0] sel_q, nr_q;
  logic [2:0] demand, active, led_flip;

  assign {pol_q, sel_q, nr_q, pdis_q, gang_q} = held;
  assign use_straps = cfg_ready && (sel_q == 2'b10);

  assign cfg_mode      = !cfg_ready ? 2'd0 : !sel_q[1] ? 2'd1 : sel_q[0] ? 2'd3 : 2'd2;
  assign port_off      = (use_straps && pdis_q) ? 3'b100 : 3'b000;
  assign non_removable = use_straps ? {nr_q == 2'b11, nr_q[1], nr_q != 2'b00} : 3'b000;
  assign ganged        = use_straps && gang_q;

  assign demand   = ganged ? {3{pwr_req[0]}} : pwr_req;
  assign active   = demand & ~port_off;
  assign pwr_en   = !cfg_ready ? {3{~strap_pol}} : (pol_q ? active : ~active);
  assign led_flip = use_straps ? {pdis_q, nr_q} : 3'b111;
  assign led_out  = cfg_ready ? (led_req ^ led_flip) : 3'b000;

  always @(posedge clk)
    if (!rst_n) assert_reset_safe_R1: assert (pwr_en == {3{~strap_pol}} && led_out == 3'b000);

  assert_config_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> $stable({cfg_mode, port_off, non_removable, ganged}) && cfg_ready);

  assert_nonrem_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    non_removable == 3'b000 || non_removable == 3'b001 ||
    non_removable == 3'b011 || non_removable == 3'b111);

  assert_port3_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && port_off[2]) |-> (pwr_en[2] == !pol_q));

  assert_gang_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ganged && port_off == 3'b000) |-> (pwr_en == 3'b000 || pwr_en == 3'b111));

  assert_other_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && cfg_mode != 2'd2) |-> (port_off == 3'b000 && non_removable == 3'b000 && !ganged));

endmodule

// File: tb/hub_strap_latch_tb.sv
module hub_strap_latch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_pol = 1'b1, strap_pdis = 1'b0, strap_gang = 1'b0;
  logic [1:0] strap_sel = 2'b10, strap_nonrem = 2'b00;
  logic [2:0] pwr_req = 3'b000, led_req = 3'b000;
  logic cfg_ready, ganged;
  logic [1:0] cfg_mode;
  logic [2:0] port_off, non_removable, pwr_en, led_out;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  hub_strap_latch u_dut (.*);

  // {pol,sel,nonrem,pdis,gang,pwr_req,led_req , mode,port_off,nonrem_out,ganged,pwr_en,led_out}
  localparam logic [27:0] VEC [8] = '{
    28'b1_10_00_0_0_101_011_10_000_000_0_101_011,
    28'b0_10_01_1_0_011_110_10_100_001_0_100_011,
    28'b1_10_10_0_1_001_000_10_000_011_1_111_010,
    28'b1_10_11_1_1_110_111_10_100_111_1_000_000,
    28'b1_00_11_1_1_111_101_01_000_000_0_111_010,
    28'b0_01_01_0_1_010_001_01_000_000_0_101_110,
    28'b1_11_10_1_0_110_100_11_000_000_0_110_011,
    28'b0_10_00_1_1_001_100_10_100_000_1_100_000
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state and combinational polarity following
    repeat (3) @(negedge clk);
    chk("R1", "pwr_en pol=1", pwr_en, 3'b000);
    chk("R1", "led_out", led_out, 0);
    chk("R1", "cfg_mode", cfg_mode, 0);
    chk("R1", "cfg_ready", cfg_ready, 0);
    strap_pol = 1'b0; #1;
    chk("R1", "pwr_en pol=0", pwr_en, 3'b111);
    strap_pol = 1'b1; #1;
    chk("R1", "pwr_en back", pwr_en, 3'b000);

    for (int i = 0; i < 8; i++) begin
      logic [27:0] v;
      v = VEC[i];
      @(negedge clk);
      rst_n = 1'b0;
      {strap_pol, strap_sel, strap_nonrem, strap_pdis, strap_gang, pwr_req, led_req} = v[27:15];
      #1;
      chk("R1", "pwr_en in reset", pwr_en, {3{~v[27]}});
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R2", "not ready after 2 edges", cfg_ready, 0);
      @(negedge clk);
      chk("R2", "ready on 3rd edge", cfg_ready, 1);
      chk("R4", "cfg_mode", cfg_mode, v[14:13]);
      chk("R6", "port_off", port_off, v[12:10]);
      chk("R5", "non_removable", non_removable, v[9:7]);
      chk("R7", "ganged", ganged, v[6]);
      chk("R3", "pwr_en", pwr_en, v[5:3]);
      chk("R8", "led_out", led_out, v[2:0]);
      // R2 later strap changes are ignored
      {strap_pol, strap_sel, strap_nonrem, strap_pdis, strap_gang} = ~v[27:21];
      repeat (4) @(negedge clk);
      chk("R2", "mode held", cfg_mode, v[14:13]);
      chk("R2", "port_off held", port_off, v[12:10]);
      chk("R2", "pwr_en held", pwr_en, v[5:3]);
      chk("R2", "led_out held", led_out, v[2:0]);
    end

    // last vector: pol 0, straps mode, port 3 off, ganged
    pwr_req = 3'b000; #1;
    chk("R3", "pol0 no demand", pwr_en, 3'b111);
    chk("R7", "ganged off", pwr_en, 3'b111);
    pwr_req = 3'b110; #1;
    chk("R7", "only req0 counts", pwr_en, 3'b111);
    pwr_req = 3'b101; #1;
    chk("R6", "port3 stays off", pwr_en[2], 1);
    chk("R6", "ports1-2 on", pwr_en[1:0], 2'b00);
    led_req = 3'b111; #1;
    chk("R8", "led flip", led_out, 3'b011);

    // EEPROM source: LEDs active low, fields zero
    @(negedge clk); rst_n = 1'b0;
    strap_sel = 2'b11; strap_pol = 1'b1; strap_pdis = 1'b1; strap_gang = 1'b1; strap_nonrem = 2'b11;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    led_req = 3'b001; pwr_req = 3'b100; #1;
    chk("R9", "led active low", led_out, 3'b110);
    chk("R9", "port3 usable", pwr_en, 3'b100);
    chk("R9", "fields zero", {port_off, non_removable, ganged}, 0);
    chk("R4", "eeprom mode", cfg_mode, 3);

    finish_run();
  end
endmodule